// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between the issue stage and the memory pipeline of a 32-lane SIMT core. It takes one load or store from a warp. The instruction carries a mask of active lanes and one 64-bit byte address per lane. The block sorts the active lanes by 128-byte cache line and sends one memory request for each distinct line. Each request names the line and carries the set of lanes it serves. Requests go out one at a time over a valid/ready handshake. While requests remain, the block holds off the issue stage.

A configuration input, `no_penalty`, removes the per-line serialization. In that mode the block works out how many lines the warp touches in the cycle of acceptance. It reports that count at once, drives nothing on the request port, and never stalls issue. Every finished instruction reports its request count. Three saturating totals are kept: instructions, requests, and uncoalesced instructions.

The controller has two states. In `ST_IDLE` the block accepts an instruction. The transition `ST_IDLE -> ST_SERIAL` is taken when the accepted mask is non-zero and `no_penalty` is low. The transition `ST_SERIAL -> ST_IDLE` is taken when the request that serves the last pending lane is accepted. Otherwise `ST_SERIAL` loops on itself, and an accepted instruction with a zero mask or with `no_penalty` set leaves the block in `ST_IDLE`.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `in_ready` is 1, and `req_valid`, `busy` and `done_valid` are 0. All three totals are 0.
- R2: When every active lane's address has the same bits [63:7], exactly one request is sent. Its `req_lanes` equals the mask and `done_count` is 1.
- R3: One request is sent for each distinct 128-byte line among the active lanes, one per accepted handshake. The line of each request is taken from the lowest-numbered lane not yet served. Its `req_lanes` holds every unserved active lane whose address has those bits [63:7]. Bit i of a mask is lane i, and lane i's address is `in_addr[64*i +: 64]`.
- R4: A lane whose mask bit is 0 does not appear in any request, and its address does not affect any request.
- R5: An accepted instruction with an all-zero mask sends no request. One cycle later it raises `done_valid` with `done_count` 0.
- R6: From the cycle after acceptance until the cycle after the last request is accepted, `busy` is 1 and `in_ready` is 0. While `req_valid` is 1 and `req_ready` is 0, `req_line` and `req_lanes` hold.
- R7: When `no_penalty` is 1 at acceptance, no request is sent and `in_ready` stays 1. One cycle later `done_valid` rises with `done_count` equal to the number of distinct lines among the active lanes.
- R8: `done_valid` is a one-cycle pulse in the cycle after the instruction's final event. In serial mode `done_count` equals the number of requests sent.
- R9: At each `done_valid`, `stat_insts` increases by 1 and `stat_reqs` increases by `done_count`. `stat_uncoal` increases by 1 when `done_count` is above 1.
- R10: Each total is STAT_W bits wide (32 by default) and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered by the issue stage |
| in_ready | output | 1 | Block can accept an instruction |
| in_mask | input | LANES | Active-lane mask |
| in_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane i at [ADDR_W*i +: ADDR_W] |
| no_penalty | input | 1 | Report all requests at once, no serialization |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory pipeline accepts the request |
| req_line | output | TAG_W | Line tag (address bits [63:7]) |
| req_lanes | output | LANES | Lanes served by this request |
| busy | output | 1 | Issue-stage stall while requests remain |
| done_valid | output | 1 | Instruction finished pulse |
| done_count | output | CNT_W | Requests generated by the finished instruction |
| stat_insts | output | STAT_W | Saturating instruction total |
| stat_reqs | output | STAT_W | Saturating request total |
| stat_uncoal | output | STAT_W | Saturating uncoalesced-instruction total |

## Verification
An instruction is accepted on a clock edge. Its first request, together with `busy`, appears after that one register stage. Each request accepted on an edge is replaced by the next request, or by `done_valid` and the updated totals, at the following edge. For zero-mask and `no_penalty` instructions, `done_valid` is due one cycle after acceptance. The bench drives inputs at the falling edge and samples at the next falling edge. It checks each request against a line list computed from the lane addresses. When it withholds `req_ready`, it checks the same expected request again, so a moving request is caught. It checks `done_valid` and the totals in the sample right after the final handshake, and checks that `done_valid` has dropped one sample later.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SERIAL = 1'b1
    } coal_state_e;
endpackage

// File: rtl/coal_lowest_lane.sv
module coal_lowest_lane #(
    parameter int N = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     bits_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = |bits_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
    parameter int N     = 32,
    parameter int TAG_W = 57
) (
    input  logic [N-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]        key_i,
    input  logic [N-1:0]            en_i,
    output logic [N-1:0]            hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign hit_o[g] = en_i[g] && (tags_i[g] == key_i);
    end
endmodule

// File: rtl/coal_line_count.sv
module coal_line_count #(
    parameter int N     = 32,
    parameter int TAG_W = 57,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0][TAG_W-1:0] tags_i,
    input  logic [N-1:0]            en_i,
    output logic [CNT_W-1:0]        count_o
);
    logic [N-1:0] first_of_line;

    for (genvar g = 0; g < N; g++) begin : g_lead
        always_comb begin
            first_of_line[g] = en_i[g];
            for (int j = 0; j < g; j++) begin
                if (en_i[j] && tags_i[j] == tags_i[g]) first_of_line[g] = 1'b0;
            end
        end
    end

    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) count_o = count_o + CNT_W'(first_of_line[i]);
    end
endmodule

// File: rtl/coal_stats.sv
module coal_stats #(
    parameter int STAT_W = 32,
    parameter int CNT_W  = 6,
    localparam int EXT_W = ((STAT_W > CNT_W) ? STAT_W : CNT_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin_i,
    input  logic [CNT_W-1:0]  fin_count_i,
    output logic [STAT_W-1:0] insts_o,
    output logic [STAT_W-1:0] reqs_o,
    output logic [STAT_W-1:0] uncoal_o
);
    localparam logic [EXT_W-1:0] TOP = EXT_W'({STAT_W{1'b1}});

    logic [EXT_W-1:0] req_sum;
    assign req_sum = EXT_W'(reqs_o) + EXT_W'(fin_count_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insts_o  <= '0;
            reqs_o   <= '0;
            uncoal_o <= '0;
        end else if (fin_i) begin
            if (~&insts_o) insts_o <= insts_o + 1'b1;
            reqs_o <= (req_sum > TOP) ? TOP[STAT_W-1:0] : req_sum[STAT_W-1:0];
            if (fin_count_i > CNT_W'(1) && ~&uncoal_o) uncoal_o <= uncoal_o + 1'b1;
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 64,
    parameter int LINE_BYTES = 128,
    parameter int STAT_W     = 32,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int TAG_W = ADDR_W - OFF_W,
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES-1:0]        in_mask,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic                    no_penalty,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [TAG_W-1:0]        req_line,
    output logic [LANES-1:0]        req_lanes,
    output logic                    busy,
    output logic                    done_valid,
    output logic [CNT_W-1:0]        done_count,
    output logic [STAT_W-1:0]       stat_insts,
    output logic [STAT_W-1:0]       stat_reqs,
    output logic [STAT_W-1:0]       stat_uncoal
);
    coal_state_e state_q, state_d;

    logic [LANES-1:0][TAG_W-1:0] in_tags, tag_q;
    logic [LANES-1:0]            pending_q;
    logic [CNT_W-1:0]            sent_q;
    logic [CNT_W-1:0]            in_lines;
    logic [IDX_W-1:0]            lead_idx;
    logic                        lead_found;
    logic [LANES-1:0]            served;
    logic                        accept, instant, last_fire, fin;
    logic [CNT_W-1:0]            fin_count;

    for (genvar g = 0; g < LANES; g++) begin : g_tag
        assign in_tags[g] = in_addr[g*ADDR_W + OFF_W +: TAG_W];
    end

    coal_line_count #(.N(LANES), .TAG_W(TAG_W)) u_count (
        .tags_i (in_tags),
        .en_i   (in_mask),
        .count_o(in_lines)
    );

    coal_lowest_lane #(.N(LANES)) u_lowest (
        .bits_i (pending_q),
        .found_o(lead_found),
        .idx_o  (lead_idx)
    );

    coal_line_match #(.N(LANES), .TAG_W(TAG_W)) u_match (
        .tags_i(tag_q),
        .key_i (tag_q[lead_idx]),
        .en_i  (pending_q),
        .hit_o (served)
    );

    assign accept    = in_valid && in_ready;
    assign instant   = accept && (no_penalty || in_mask == '0);
    assign last_fire = req_valid && req_ready && ((pending_q & ~served) == '0);
    assign fin       = instant || last_fire;
    assign fin_count = instant ? in_lines : sent_q + 1'b1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && !instant) state_d = ST_SERIAL;
            ST_SERIAL: if (last_fire) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q  <= '0;
            tag_q      <= '0;
            sent_q     <= '0;
            done_valid <= 1'b0;
            done_count <= '0;
        end else begin
            done_valid <= fin;
            if (fin) done_count <= fin_count;
            if (accept && !instant) begin
                pending_q <= in_mask;
                tag_q     <= in_tags;
                sent_q    <= '0;
            end else if (req_valid && req_ready) begin
                pending_q <= pending_q & ~served;
                sent_q    <= sent_q + 1'b1;
            end
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        busy      = 1'b0;
        req_valid = 1'b0;
        req_line  = tag_q[lead_idx];
        req_lanes = served;
        unique case (state_q)
            ST_IDLE:   in_ready = 1'b1;
            ST_SERIAL: begin
                busy      = 1'b1;
                req_valid = lead_found;
            end
            default: ;
        endcase
    end

    coal_stats #(.STAT_W(STAT_W), .CNT_W(CNT_W)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin_i      (fin),
        .fin_count_i(fin_count),
        .insts_o    (stat_insts),
        .reqs_o     (stat_reqs),
        .uncoal_o   (stat_uncoal)
    );
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
    parameter int LANES  = 32,
    parameter int TAG_W  = 57,
    parameter int CNT_W  = 6,
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [LANES-1:0]  in_mask,
    input logic              no_penalty,
    input logic              req_valid,
    input logic              req_ready,
    input logic [TAG_W-1:0]  req_line,
    input logic [LANES-1:0]  req_lanes,
    input logic              busy,
    input logic              done_valid,
    input logic [CNT_W-1:0]  done_count,
    input logic [STAT_W-1:0] stat_insts,
    input logic [STAT_W-1:0] stat_reqs,
    input logic [STAT_W-1:0] stat_uncoal
);
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_line) && $stable(req_lanes));

    // R6
    req_stalls_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy && !in_ready);

    // R3
    req_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones(req_lanes) >= 1);

    // R5
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mask == '0 |=> done_valid && done_count == '0 && !req_valid);

    // R7
    no_penalty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && no_penalty |=> done_valid && !req_valid && in_ready);

    // R8
    done_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> done_count <= CNT_W'(LANES));

    // R9
    stats_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_insts >= $past(stat_insts) && stat_reqs >= $past(stat_reqs)
        && stat_uncoal >= $past(stat_uncoal));
endmodule

bind warp_coalescer warp_coalescer_chk #(
    .LANES (LANES),
    .TAG_W (TAG_W),
    .CNT_W (CNT_W),
    .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;
    localparam int L  = 32;
    localparam int AW = 64;
    localparam int TW = 57;
    localparam int SW = 8;
    localparam logic [SW-1:0] SMAX = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [L-1:0]    in_mask = '0;
    logic [L*AW-1:0] in_addr = '0;
    logic            no_penalty = 1'b0;
    logic            req_valid;
    logic            req_ready = 1'b0;
    logic [TW-1:0]   req_line;
    logic [L-1:0]    req_lanes;
    logic            busy;
    logic            done_valid;
    logic [5:0]      done_count;
    logic [SW-1:0]   stat_insts, stat_reqs, stat_uncoal;

    always #4 clk = ~clk;

    warp_coalescer #(.STAT_W(SW)) dut (.*);

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] a [L];
    logic [TW-1:0] e_line [L];
    logic [L-1:0]  e_lanes [L];
    int e_n;
    int m_insts = 0, m_reqs = 0, m_unc = 0;

    task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic build_model(logic [L-1:0] m);
        logic [L-1:0] pend = m;
        e_n = 0;
        while (pend != '0) begin
            int p = 0;
            while (!pend[p]) p++;
            e_line[e_n] = a[p][63:7];
            e_lanes[e_n] = '0;
            for (int i = 0; i < L; i++)
                if (pend[i] && a[i][63:7] == a[p][63:7]) e_lanes[e_n][i] = 1'b1;
            pend = pend & ~e_lanes[e_n];
            e_n++;
        end
    endtask

    function automatic int sat(int v);
        return (v > int'(SMAX)) ? int'(SMAX) : v;
    endfunction

    task automatic run(string r, logic [L-1:0] m, logic np, int stall);
        int k = 0;
        int cyc = 0;
        @(negedge clk);
        for (int i = 0; i < L; i++) in_addr[i*AW +: AW] = a[i];
        in_mask = m; no_penalty = np; in_valid = 1'b1;
        build_model(m);
        @(negedge clk);
        in_valid = 1'b0;
        if (np || m == '0) begin
            chk({r, " no request"}, req_valid, 0);
            chk({r, " ready kept"}, in_ready, 1);
        end else begin
            while (k < e_n) begin
                chk({r, " R6 busy"}, {busy, in_ready}, 2'b10);
                chk({r, " req_valid"}, req_valid, 1);
                chk({r, " R3 line"}, req_line, e_line[k]);
                chk({r, " R3 lanes"}, req_lanes, e_lanes[k]);
                req_ready = (stall == 0) || (cyc % stall != 0);
                @(negedge clk);
                if (req_ready) k++;
                cyc++;
            end
            req_ready = 1'b0;
            chk({r, " R6 released"}, {busy, in_ready, req_valid}, 3'b010);
        end
        chk({r, " R8 done"}, done_valid, 1);
        chk({r, " R8 count"}, done_count, e_n);
        m_insts = sat(m_insts + 1);
        m_reqs  = sat(m_reqs + e_n);
        if (e_n > 1) m_unc = sat(m_unc + 1);
        chk({r, " R9 insts"}, stat_insts, m_insts);
        chk({r, " R9 R10 reqs"}, stat_reqs, m_reqs);
        chk({r, " R9 uncoal"}, stat_uncoal, m_unc);
        @(negedge clk);
        chk({r, " R8 pulse"}, done_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1 idle", {in_ready, req_valid, busy, done_valid}, 4'b1000);
        chk("R1 stats", {stat_insts, stat_reqs, stat_uncoal}, 0);
    endtask

    task automatic t_same_line();
        for (int i = 0; i < L; i++) a[i] = 64'h1000_0000 + 64'(i * 4);
        run("R2 same line", '1, 1'b0, 0);
    endtask

    task automatic t_scatter();
        for (int i = 0; i < L; i++) a[i] = 64'h2000_0000 + 64'(((i * 3) % 5) * 128) + 64'(i);
        run("R3 five lines with stalls", '1, 1'b0, 3);
    endtask

    task automatic t_inactive();
        for (int i = 0; i < L; i++) a[i] = 64'hDEAD_0000_0000 + 64'(i * 4096);
        for (int i = 4; i < 8; i++) a[i] = 64'h3000_0040 + 64'(i);
        run("R4 inactive lanes", 32'h0000_00F0, 1'b0, 2);
    endtask

    task automatic t_empty();
        run("R5 empty mask", '0, 1'b0, 0);
    endtask

    task automatic t_no_penalty();
        for (int i = 0; i < L; i++) a[i] = 64'(i) * 64'h1000;
        run("R7 no penalty", '1, 1'b1, 0);
        for (int i = 0; i < L; i++) a[i] = 64'h4000 + 64'((i % 3) * 256);
        run("R7 no penalty partial", 32'h00FF_00FF, 1'b1, 0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < L; i++) a[i] = 64'(L - i) * 64'h80;
        for (int n = 0; n < 8; n++) run("R10 saturate", '1, 1'b0, 0);
        chk("R10 reqs at max", stat_reqs, SMAX);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_same_line();
        t_scatter();
        t_inactive();
        t_empty();
        t_no_penalty();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule